// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the master side of a three-wire link to a 64-word by 16-bit serial EEPROM. A client presents a command code, a word address and, for programming, a data word, then pulses a start strobe. The controller builds the serial frame and drives chip select, the serial clock and the serial data line from the system clock. During a read it gathers the returned bits into a 16-bit word. After a command that changes the array it checks the device's ready status, and then pulses done.

The serial clock timing comes from parameters: the number of system cycles in each clock half, the number of cycles chip select stays low between frames, and a limit on the status wait. The default values give 250 ns halves and 250 ns low gaps at a 100 MHz system clock, and a 5 ms status limit. If the limit is reached, an error flag is raised and the command still finishes.

Top module: `eep3w_host`

## Requirements
- R1: A start is taken only while busy is low. Busy rises in the next cycle and stays high up to and including the one-cycle done pulse. Starts seen while busy is high cause no extra frame.
- R2: Each frame begins with CS rising. It carries a 1, then a 2-bit opcode (read 10, write 01, erase 11, special 00), then 6 address bits MSB first. The command codes on cmdOp are: 0 read, 1 write, 2 erase, 3 program-enable, 4 program-disable, 5 erase-all, 6 write-all, 7 same as 4. Special commands put a code in the top two address bits (enable 11, disable 00, erase-all 10, write-all 01) and zeros below it. Write and write-all add 16 data bits MSB first.
- R3: Each bit holds SK low for HALF_DIV cycles and then high for HALF_DIV cycles. DI changes only at the start of the low half. CS rises with SK low, HALF_DIV cycles before the first rising SK edge.
- R4: After the last bit, CS, SK and DI stay low for CS_LOW_CYC cycles. CS never rises after fewer than CS_LOW_CYC low cycles.
- R5: A read sends 26 SK pulses, with DI low after the address. DO is sampled at the end of each high half. The first sampled bit is discarded and the next 16 form rdData MSB first. rdData keeps its value until the next read finishes.
- R6: For read, enable and disable, done is high in the cycle right after the CS low gap, which is 2*HALF_DIV*bits + CS_LOW_CYC + 1 cycles after the start is taken.
- R7: For write, erase, erase-all and write-all, CS is raised again after the gap, and DO is ignored for HALF_DIV cycles. The first 1 after that ends the check. A second CS low gap follows, then done. Done never comes while the device still reports busy.
- R8: If DO shows no 1 within POLL_TIMEOUT cycles of the status CS going high, timeoutErr is set and CS drops. Done then follows one CS_LOW_CYC gap later. timeoutErr stays set until the next start is taken.
- R9: After reset and whenever busy is low, CS, SK and DI are low, done is low and rdData is 0 after reset. Done lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdStart | input | 1 | Start strobe, taken while idle |
| cmdOp | input | 3 | Command code |
| cmdAddr | input | ADDR_W | Word address |
| cmdWdata | input | DATA_W | Data for write and write-all |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Last word read |
| timeoutErr | output | 1 | Status wait exceeded the limit |
| eeCs | output | 1 | Serial chip select |
| eeSk | output | 1 | Serial clock |
| eeDi | output | 1 | Serial data to the device |
| eeDo | input | 1 | Serial data and status from the device |

## Verification
The bench builds the controller with HALF_DIV=2, CS_LOW_CYC=3 and POLL_TIMEOUT=60. With these values a 26-bit read fits in about a hundred cycles, so every frame shape and opcode can be compared cycle by cycle against a queue of expected pin values. A behavioural device on the far side of the pins holds its busy status for 20 cycles, which falls well inside the status limit. It can also be made to stay busy forever, so the 60-cycle timeout path, and its exact done cycle, is reached in a short run.

// File: rtl/eep3w_pkg.sv
package eep3w_pkg;

  localparam logic [2:0] OP_READ  = 3'd0;
  localparam logic [2:0] OP_WRITE = 3'd1;
  localparam logic [2:0] OP_ERASE = 3'd2;
  localparam logic [2:0] OP_WREN  = 3'd3;
  localparam logic [2:0] OP_WRDIS = 3'd4;
  localparam logic [2:0] OP_ERALL = 3'd5;
  localparam logic [2:0] OP_WRALL = 3'd6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_POLL,
    ST_DONE
  } hostState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic capture;
  } dpStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic lastBit;
    logic progCmd;
  } dpStatus_t;

endpackage

// File: rtl/eep3w_datapath.sv
module eep3w_datapath
  import eep3w_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic              eeDo,
  output dpStatus_t         status,
  output logic              diBit,
  output logic [DATA_W-1:0] rdData
);

  localparam int CMD_BITS = 3 + ADDR_W;
  localparam int FRAME_W  = CMD_BITS + DATA_W;
  localparam int READ_LEN = CMD_BITS + 1 + DATA_W;
  localparam int LEN_W    = $clog2(READ_LEN + 1);

  logic [1:0]        opBits;
  logic [ADDR_W-1:0] addrField;
  logic              hasData;
  logic              rdCmd;
  logic              pgCmd;
  logic [FRAME_W-1:0] frameNext;
  logic [LEN_W-1:0]  lenNext;

  logic [FRAME_W-1:0] frameReg;
  logic [LEN_W-1:0]  frameLen;
  logic [LEN_W-1:0]  bitCnt;
  logic              isRead;
  logic              isProg;
  logic [DATA_W-1:0] rdReg;

  // command decode into opcode, address field and frame shape
  always_comb begin
    opBits    = 2'b00;
    addrField = '0;
    hasData   = 1'b0;
    rdCmd     = 1'b0;
    pgCmd     = 1'b0;
    case (cmdOp)
      OP_READ: begin
        opBits    = 2'b10;
        addrField = cmdAddr;
        rdCmd     = 1'b1;
      end
      OP_WRITE: begin
        opBits    = 2'b01;
        addrField = cmdAddr;
        hasData   = 1'b1;
        pgCmd     = 1'b1;
      end
      OP_ERASE: begin
        opBits    = 2'b11;
        addrField = cmdAddr;
        pgCmd     = 1'b1;
      end
      OP_WREN: begin
        addrField[ADDR_W-1 -: 2] = 2'b11;
      end
      OP_ERALL: begin
        addrField[ADDR_W-1 -: 2] = 2'b10;
        pgCmd     = 1'b1;
      end
      OP_WRALL: begin
        addrField[ADDR_W-1 -: 2] = 2'b01;
        hasData   = 1'b1;
        pgCmd     = 1'b1;
      end
      default: begin
        addrField = '0;
      end
    endcase
  end

  assign frameNext = {1'b1, opBits, addrField, (hasData ? cmdWdata : {DATA_W{1'b0}})};
  assign lenNext   = rdCmd   ? LEN_W'(READ_LEN) :
                     hasData ? LEN_W'(FRAME_W)  : LEN_W'(CMD_BITS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '0;
      frameLen <= '0;
      bitCnt   <= '0;
      isRead   <= 1'b0;
      isProg   <= 1'b0;
    end else if (strobe.load) begin
      frameReg <= frameNext;
      frameLen <= lenNext;
      bitCnt   <= '0;
      isRead   <= rdCmd;
      isProg   <= pgCmd;
    end else if (strobe.shift) begin
      frameReg <= {frameReg[FRAME_W-2:0], 1'b0};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  // bit CMD_BITS is the leading dummy of a read and is skipped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdReg <= '0;
    end else if (strobe.capture && isRead && (bitCnt > LEN_W'(CMD_BITS))) begin
      rdReg <= {rdReg[DATA_W-2:0], eeDo};
    end
  end

  assign diBit          = frameReg[FRAME_W-1];
  assign status.lastBit = (bitCnt == frameLen - 1'b1);
  assign status.progCmd = isProg;
  assign rdData         = rdReg;

endmodule

// File: rtl/eep3w_ctrl.sv
module eep3w_ctrl
  import eep3w_pkg::*;
#(
  parameter int HALF_DIV     = 25,
  parameter int CS_LOW_CYC   = 25,
  parameter int POLL_TIMEOUT = 500000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdStart,
  input  logic      eeDo,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      eeCs,
  output logic      eeSk,
  output logic      diGate,
  output logic      busy,
  output logic      done,
  output logic      timeoutErr
);

  localparam int HALF_W   = $clog2(HALF_DIV + 1);
  localparam int WAIT_MAX = (CS_LOW_CYC > POLL_TIMEOUT) ? CS_LOW_CYC : POLL_TIMEOUT;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  hostState_t        state;
  logic [HALF_W-1:0] halfCnt;
  logic              skHigh;
  logic [WAIT_W-1:0] waitCnt;
  logic              polled;
  logic              errFlag;
  logic              halfEnd;
  logic              pollReady;

  assign halfEnd   = (halfCnt == HALF_W'(HALF_DIV - 1));
  assign pollReady = (waitCnt >= WAIT_W'(HALF_DIV)) && eeDo;

  always_comb begin
    strobe.load    = (state == ST_IDLE) && cmdStart;
    strobe.shift   = (state == ST_SHIFT) && halfEnd && skHigh;
    strobe.capture = (state == ST_SHIFT) && halfEnd && skHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      skHigh  <= 1'b0;
      waitCnt <= '0;
      polled  <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmdStart) begin
            state   <= ST_SHIFT;
            halfCnt <= '0;
            skHigh  <= 1'b0;
            polled  <= 1'b0;
            errFlag <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (halfEnd) begin
            halfCnt <= '0;
            if (!skHigh) begin
              skHigh <= 1'b1;
            end else begin
              skHigh <= 1'b0;
              if (status.lastBit) begin
                state   <= ST_GAP;
                waitCnt <= '0;
              end
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (waitCnt == WAIT_W'(CS_LOW_CYC - 1)) begin
            waitCnt <= '0;
            state   <= (status.progCmd && !polled) ? ST_POLL : ST_DONE;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_POLL: begin
          if (pollReady) begin
            polled  <= 1'b1;
            state   <= ST_GAP;
            waitCnt <= '0;
          end else if (waitCnt == WAIT_W'(POLL_TIMEOUT - 1)) begin
            errFlag <= 1'b1;
            polled  <= 1'b1;
            state   <= ST_GAP;
            waitCnt <= '0;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign eeCs       = (state == ST_SHIFT) || (state == ST_POLL);
  assign eeSk       = (state == ST_SHIFT) && skHigh;
  assign diGate     = (state == ST_SHIFT);
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);
  assign timeoutErr = errFlag;

endmodule

// File: rtl/eep3w_host.sv
module eep3w_host
  import eep3w_pkg::*;
#(
  parameter int HALF_DIV     = 25,
  parameter int CS_LOW_CYC   = 25,
  parameter int POLL_TIMEOUT = 500000,
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              timeoutErr,
  output logic              eeCs,
  output logic              eeSk,
  output logic              eeDi,
  input  logic              eeDo
);

  dpStrobe_t strobe;
  dpStatus_t status;
  logic      diGate;
  logic      diBit;

  eep3w_ctrl #(
    .HALF_DIV    (HALF_DIV),
    .CS_LOW_CYC  (CS_LOW_CYC),
    .POLL_TIMEOUT(POLL_TIMEOUT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdStart  (cmdStart),
    .eeDo      (eeDo),
    .status    (status),
    .strobe    (strobe),
    .eeCs      (eeCs),
    .eeSk      (eeSk),
    .diGate    (diGate),
    .busy      (busy),
    .done      (done),
    .timeoutErr(timeoutErr)
  );

  eep3w_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cmdOp   (cmdOp),
    .cmdAddr (cmdAddr),
    .cmdWdata(cmdWdata),
    .eeDo    (eeDo),
    .status  (status),
    .diBit   (diBit),
    .rdData  (rdData)
  );

  assign eeDi = diGate & diBit;

endmodule

// File: rtl/eep3w_checks.sv
module eep3w_checks #(
  parameter int HALF_DIV   = 25,
  parameter int CS_LOW_CYC = 25
) (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic timeoutErr,
  input logic eeCs,
  input logic eeSk,
  input logic eeDi
);

  localparam int HW = $clog2(HALF_DIV + 1);
  localparam int GW = $clog2(CS_LOW_CYC + 1);

  logic [GW-1:0] csLowRun;
  logic [HW-1:0] skLowRun;
  logic [HW-1:0] skHighRun;

  // run lengths saturate; reset counts as a long idle stretch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csLowRun  <= GW'(CS_LOW_CYC);
      skLowRun  <= HW'(HALF_DIV);
      skHighRun <= '0;
    end else begin
      if (eeCs) csLowRun <= '0;
      else if (csLowRun != GW'(CS_LOW_CYC)) csLowRun <= csLowRun + 1'b1;
      if (eeSk) skLowRun <= '0;
      else if (skLowRun != HW'(HALF_DIV)) skLowRun <= skLowRun + 1'b1;
      if (!eeSk) skHighRun <= '0;
      else if (skHighRun != HW'(HALF_DIV)) skHighRun <= skHighRun + 1'b1;
    end
  end

  assert_busy_holds_R1: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> busy);
  assert_done_ends_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  assert_sk_inside_cs_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeSk) |-> eeCs && $past(eeCs));
  assert_di_steady_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    eeSk |-> $stable(eeDi));
  assert_sk_low_time_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeSk) |-> skLowRun >= HW'(HALF_DIV));
  assert_sk_high_time_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eeSk) |-> skHighRun >= HW'(HALF_DIV));
  assert_cs_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeCs) |-> csLowRun >= GW'(CS_LOW_CYC));
  assert_err_sets_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> busy && !eeCs);
  assert_err_clears_on_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timeoutErr) |-> $rose(busy));
  assert_idle_pins_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !eeCs && !eeSk && !eeDi);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind eep3w_host eep3w_checks #(
  .HALF_DIV  (HALF_DIV),
  .CS_LOW_CYC(CS_LOW_CYC)
) u_checks (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .done      (done),
  .timeoutErr(timeoutErr),
  .eeCs      (eeCs),
  .eeSk      (eeSk),
  .eeDi      (eeDi)
);

// File: tb/tb_eep3w_host.sv
module tb_eep3w_host;

  localparam int H    = 2;
  localparam int G    = 3;
  localparam int T    = 60;
  localparam int BUSY = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdStart = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [5:0]  cmdAddr = 6'd0;
  logic [15:0] cmdWdata = 16'd0;
  logic        eeDo = 1'b0;
  logic        busy, done, timeoutErr, eeCs, eeSk, eeDi;
  logic [15:0] rdData;

  always #5 clk = ~clk;

  eep3w_host #(.HALF_DIV(H), .CS_LOW_CYC(G), .POLL_TIMEOUT(T), .ADDR_W(6), .DATA_W(16)) dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdWdata(cmdWdata), .busy(busy), .done(done), .rdData(rdData), .timeoutErr(timeoutErr),
    .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi), .eeDo(eeDo));

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // behavioural device on the serial pins
  logic [15:0] mem [64];
  logic [15:0] shadow [64];
  bit          we = 0;
  bit          stuck = 0;
  int          sBusy = 0;
  int          sBits = 0;
  logic [31:0] rx = '0;
  logic        sStart = 0;
  logic [1:0]  sOp = '0;
  logic [5:0]  sAddr = '0;
  int          frames = 0;
  int          polls = 0;
  logic        prevCs = 0, prevSk = 0;
  int          lastBits = 0;
  logic        lastStart = 0;
  logic [1:0]  lastOp = '0;
  logic [5:0]  lastAddr = '0;
  logic [15:0] lastData = '0;

  logic [3:0]  expQ [$];
  int          expLen;
  logic [1:0]  expOc;
  logic [5:0]  expAf;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishDevFrame();
    lastBits = sBits; lastStart = sStart; lastOp = sOp; lastAddr = sAddr;
    lastData = rx[15:0];
    case (sOp)
      2'b01: if (we) begin mem[sAddr] = rx[15:0]; sBusy = BUSY; end
      2'b11: if (we) begin mem[sAddr] = 16'hFFFF; sBusy = BUSY; end
      2'b00: begin
        case (sAddr[5:4])
          2'b11: we = 1;
          2'b00: we = 0;
          2'b10: if (we) begin
            for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
            sBusy = BUSY;
          end
          default: if (we) begin
            for (int i = 0; i < 64; i++) mem[i] = rx[15:0];
            sBusy = BUSY;
          end
        endcase
      end
      default: ;
    endcase
  endtask

  // one cycle: sample away from the rising edge, compare, update the device
  task automatic step();
    logic [3:0] e;
    @(negedge clk);
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      check({eeCs, eeSk, eeDi} == e[2:0], e[3] ? "R4" : "R3", "pins cs/sk/di",
            {eeCs, eeSk, eeDi}, e[2:0]);
    end else if (!busy) begin
      check({eeCs, eeSk, eeDi} == 3'b000, "R9", "idle pins", {eeCs, eeSk, eeDi}, 0);
    end
    if (sBusy > 0 && !stuck) sBusy--;
    if (eeSk && !prevSk && eeCs) begin
      rx = {rx[30:0], eeDi};
      sBits++;
      if (sBits == 9) begin sStart = rx[8]; sOp = rx[7:6]; sAddr = rx[5:0]; end
      if (sBits >= 10 && sOp == 2'b10)
        eeDo = (sBits == 10) ? 1'b0 : mem[sAddr][15-(sBits-11)];
    end else if (eeCs && sBits == 0) begin
      eeDo = (sBusy == 0);
    end
    if (prevCs && !eeCs) begin
      if (sBits >= 9) begin frames++; finishDevFrame(); end
      else polls++;
      sBits = 0;
    end
    if (!eeCs) eeDo = 1'b0;
    prevCs = eeCs; prevSk = eeSk;
  endtask

  task automatic pushBit(input logic b);
    for (int k = 0; k < H; k++) expQ.push_back({1'b0, 1'b1, 1'b0, b});
    for (int k = 0; k < H; k++) expQ.push_back({1'b0, 1'b1, 1'b1, b});
  endtask

  task automatic buildExp(input logic [2:0] op, input logic [5:0] addr, input logic [15:0] data);
    int nData;
    nData = 0;
    case (op)
      3'd0: begin expOc = 2'b10; expAf = addr; nData = 17; end
      3'd1: begin expOc = 2'b01; expAf = addr; nData = 16; end
      3'd2: begin expOc = 2'b11; expAf = addr; end
      3'd3: begin expOc = 2'b00; expAf = 6'b110000; end
      3'd5: begin expOc = 2'b00; expAf = 6'b100000; end
      3'd6: begin expOc = 2'b00; expAf = 6'b010000; nData = 16; end
      default: begin expOc = 2'b00; expAf = 6'b000000; end
    endcase
    expLen = 9 + nData;
    pushBit(1'b1);
    pushBit(expOc[1]); pushBit(expOc[0]);
    for (int i = 5; i >= 0; i--) pushBit(expAf[i]);
    if (nData == 16) for (int i = 15; i >= 0; i--) pushBit(data[i]);
    if (nData == 17) for (int i = 0; i < 17; i++) pushBit(1'b0);
    for (int k = 0; k < G; k++) expQ.push_back(4'b1000);
  endtask

  task automatic runCmd(input logic [2:0] op, input logic [5:0] addr, input logic [15:0] data,
                        input int inject, input bit expTimeout);
    int n, doneAt, fr0, pl0, frameCyc;
    bit prog;
    prog = (op == 3'd1) || (op == 3'd2) || (op == 3'd5) || (op == 3'd6);
    check(!busy, "R1", "busy before start", busy, 0);
    cmdOp = op; cmdAddr = addr; cmdWdata = data; cmdStart = 1'b1;
    buildExp(op, addr, data);
    frameCyc = expLen * 2 * H;
    fr0 = frames; pl0 = polls;
    n = 0; doneAt = -1;
    while (doneAt < 0 && n < 5000) begin
      step();
      n++;
      if (n == 1) begin
        cmdStart = 1'b0;
        check(busy, "R1", "busy after start", busy, 1);
        check(!timeoutErr, "R8", "error cleared by start", timeoutErr, 0);
      end
      if (inject > 0 && n == inject) begin cmdStart = 1'b1; cmdOp = 3'd1; cmdAddr = 6'd0; end
      if (inject > 0 && n == inject + 1) cmdStart = 1'b0;
      if (done) doneAt = n;
    end
    check(doneAt > 0, "R1", "done seen", doneAt, 1);
    check(frames == fr0 + 1, "R1", "frames per command", frames - fr0, 1);
    check(lastStart == 1'b1, "R2", "start bit", lastStart, 1);
    check(lastOp == expOc, "R2", "opcode", lastOp, expOc);
    check(lastAddr == expAf, "R2", "address field", lastAddr, expAf);
    check(lastBits == expLen, "R2", "frame length", lastBits, expLen);
    if (op == 3'd1 || op == 3'd6) check(lastData == data, "R2", "data field", lastData, data);
    if (expTimeout) begin
      check(doneAt == frameCyc + G + T + G + 1, "R8", "timeout done cycle", doneAt, frameCyc + 2*G + T + 1);
      check(timeoutErr, "R8", "timeoutErr at done", timeoutErr, 1);
    end else if (prog) begin
      check(doneAt > frameCyc + G, "R7", "done after status", doneAt, frameCyc + G + 1);
      check(sBusy == 0, "R7", "device ready at done", sBusy, 0);
      check(!timeoutErr, "R8", "no timeout", timeoutErr, 0);
    end else begin
      check(doneAt == frameCyc + G + 1, "R6", "done cycle", doneAt, frameCyc + G + 1);
    end
    check(polls == pl0 + (prog ? 1 : 0), "R7", "status phases", polls - pl0, prog ? 1 : 0);
    step();
    check(!done && !busy, "R9", "single done pulse", {done, busy}, 0);
  endtask

  task automatic readCheck(input logic [5:0] addr, input int inject);
    runCmd(3'd0, addr, 16'h0, inject, 1'b0);
    check(rdData == shadow[addr], "R5", "read data", rdData, shadow[addr]);
  endtask

  initial begin
    #(150000 * 10);
    if (!finished) begin
      check(1'b0, "R1", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 16'(i * 257) ^ 16'hA5C3;
      shadow[i] = mem[i];
    end
    repeat (3) step();
    check({busy, done, timeoutErr} == 3'b000, "R9", "reset flags", {busy, done, timeoutErr}, 0);
    check({eeCs, eeSk, eeDi} == 3'b000, "R9", "reset pins", {eeCs, eeSk, eeDi}, 0);
    check(rdData == 16'h0, "R9", "reset rdData", rdData, 0);
    rstN = 1'b1;
    step();

    readCheck(6'd5, 0);
    readCheck(6'd63, 0);
    runCmd(3'd3, 6'h15, 16'h0, 0, 1'b0);
    check(rdData == shadow[63], "R5", "rdData held", rdData, shadow[63]);
    check(we == 1, "R2", "enable reached device", we, 1);

    runCmd(3'd1, 6'h2A, 16'hBEEF, 0, 1'b0); shadow[6'h2A] = 16'hBEEF;
    readCheck(6'h2A, 0);
    runCmd(3'd1, 6'd63, 16'h8001, 0, 1'b0); shadow[63] = 16'h8001;
    readCheck(6'd63, 0);
    runCmd(3'd2, 6'h2A, 16'h0, 0, 1'b0); shadow[6'h2A] = 16'hFFFF;
    readCheck(6'h2A, 0);
    // R1: a start during a read must not launch a second frame
    readCheck(6'd63, 12);

    runCmd(3'd6, 6'h00, 16'h1234, 0, 1'b0);
    for (int i = 0; i < 64; i++) shadow[i] = 16'h1234;
    readCheck(6'd0, 0);
    readCheck(6'd63, 0);
    runCmd(3'd5, 6'h00, 16'h0, 0, 1'b0);
    for (int i = 0; i < 64; i++) shadow[i] = 16'hFFFF;
    readCheck(6'd17, 0);

    // R8: device stuck busy
    stuck = 1;
    runCmd(3'd1, 6'd3, 16'h5555, 0, 1'b1); shadow[3] = 16'h5555;
    stuck = 0; sBusy = 0;
    readCheck(6'd3, 0);

    runCmd(3'd4, 6'h3F, 16'h0, 0, 1'b0);
    check(we == 0, "R2", "disable reached device", we, 0);
    runCmd(3'd1, 6'd4, 16'h0F0F, 0, 1'b0);
    readCheck(6'd4, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule